// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit interval counter channel with six operating modes. It does not decrement a count register. It keeps the number of counting ticks that have passed since the last load or the last gate trigger. From that elapsed figure, the loaded count and the selected mode, it derives the output level and the value a reader would see as the live count. A tick enable sets the counting rate. The host drives a one-cycle load strobe together with a 16-bit count and a 3-bit mode code.

The modes are:

- Mode 0: a terminal-count level.
- Mode 1: a one-shot.
- Mode 2: a rate generator.
- Mode 3: a square wave.
- Mode 4: a software-triggered strobe.
- Mode 5: a gate-triggered strobe.

In modes 0 and 4 the gate input is a counting enable. In modes 1, 2, 3 and 5 a rising gate edge restarts the elapsed figure. The level that the gate edge detector assumes at reset is a parameter, so each channel of a set can be given its own idle gate level.

Top module: `interval_channel`

## Requirements
- R1: A load strobe stores the count and the folded mode, and it clears the elapsed figure on the same clock edge. On the next cycle the readback therefore equals the loaded value. A loaded value of 0 counts as 65536. Mode codes 6 and 7 behave as modes 2 and 3. A load takes priority over a tick or a gate edge in the same cycle.
- R2: In mode 0 the output is high exactly when elapsed is greater than or equal to the count.
- R3: In mode 1 the output is high exactly when elapsed is less than the count.
- R4: In mode 2 the elapsed figure wraps to 0 each time it reaches the count. The output is high when elapsed is a nonzero multiple of the count. The readback is the count minus (elapsed modulo count).
- R5: In mode 3 the output is high for the first (count+1)/2 ticks of each period. The readback is the count minus ((2 x elapsed) modulo count), so it falls by two per tick.
- R6: In modes 4 and 5 the output is high only while elapsed equals the count.
- R7: In modes 0, 1, 4 and 5 the readback is (count - elapsed) truncated to 16 bits. After terminal count it therefore reads 0xFFFF, 0xFFFE and so on.
- R8: In modes 1, 2, 3 and 5, a gate rising edge resets elapsed to 0. In mode 2 it also clears the record of a completed period.
- R9: In modes 0 and 4, ticks are counted only while the gate is high, and a gate rising edge does not restart counting.
- R10: In modes 0, 1, 4 and 5 the elapsed figure saturates at its all-ones value instead of wrapping. Its width is the count width plus two bits.
- R11: After reset the channel is in mode 0 with a count of 65536 and elapsed 0. The output reads low and the readback reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | One counting tick in this cycle |
| gate_i | input | 1 | Gate level |
| load_i | input | 1 | Load strobe for count and mode |
| load_val_i | input | CNT_W | Count value; 0 means 2^CNT_W |
| load_mode_i | input | 3 | Mode code 0 to 7 |
| out_o | output | 1 | Channel output level |
| rdbk_o | output | CNT_W | Current count as a reader sees it |

## Verification
The hardest condition to reach from the ports is elapsed saturation. With a 16-bit count it needs more than a quarter of a million ticks. The bench therefore adds a second instance with a 4-bit count, where saturation at 63 arrives after 70 ticks, and checks the wrapped readback value that saturation produces. The other delicate cases are gate edges that fall between ticks. The bench pulses the gate low for one cycle with no tick, so that the only change is the restart, or its absence in modes 0 and 4.

// File: rtl/ichan_pkg.sv
package ichan_pkg;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } ichan_mode_e;

    // codes 6 and 7 alias the two periodic modes
    function automatic ichan_mode_e fold_mode(input logic [2:0] m);
        logic [2:0] f;
        f = (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
        return ichan_mode_e'(f);
    endfunction

    function automatic logic is_periodic(input ichan_mode_e m);
        return (m == M_RATE) || (m == M_SQUARE);
    endfunction

    function automatic logic gate_retriggers(input ichan_mode_e m);
        return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTROBE);
    endfunction

    function automatic logic gate_enables(input ichan_mode_e m);
        return (m == M_TERM) || (m == M_SWSTROBE);
    endfunction

endpackage

// File: rtl/ichan_gate_edge.sv
module ichan_gate_edge #(
    parameter logic IDLE_GATE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic rise_o
);
    logic gate_d, gate_q;

    always_comb begin
        gate_d = gate_i;
        rise_o = gate_i & ~gate_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= IDLE_GATE;
        else        gate_q <= gate_d;
    end
endmodule

// File: rtl/ichan_tracker.sv
module ichan_tracker
    import ichan_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int EL_W  = CNT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en_i,
    input  logic              gate_i,
    input  logic              gate_rise_i,
    input  logic              load_i,
    input  logic [CNT_W-1:0]  load_val_i,
    input  logic [2:0]        load_mode_i,
    output ichan_mode_e       mode_o,
    output logic [CNT_W:0]    cnt_o,
    output logic [EL_W-1:0]   el_o,
    output logic              started_o
);
    localparam int PADW = EL_W - CNT_W - 1;
    localparam logic [CNT_W:0]  FULL   = {1'b1, {CNT_W{1'b0}}};
    localparam logic [EL_W-1:0] EL_MAX = '1;

    typedef struct packed {
        ichan_mode_e       mode;
        logic [CNT_W:0]    cnt;
        logic [EL_W-1:0]   el;
        logic              started;
    } trk_st_t;

    trk_st_t s_d, s_q;
    logic clr, adv;
    logic [EL_W-1:0] el_inc;

    always_comb begin
        s_d    = s_q;
        clr    = load_i | (gate_retriggers(s_q.mode) & gate_rise_i);
        adv    = tick_en_i & (gate_i | ~gate_enables(s_q.mode));
        el_inc = s_q.el + 1'b1;
        if (load_i) begin
            s_d.mode = fold_mode(load_mode_i);
            s_d.cnt  = (load_val_i == '0) ? FULL : {1'b0, load_val_i};
        end
        if (clr) begin
            s_d.el      = '0;
            s_d.started = 1'b0;
        end else if (adv) begin
            if (is_periodic(s_q.mode)) begin
                s_d.started = 1'b1;
                s_d.el = (el_inc == {{PADW{1'b0}}, s_q.cnt}) ? '0 : el_inc;
            end else if (s_q.el != EL_MAX) begin
                s_d.el = el_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode    <= M_TERM;
            s_q.cnt     <= FULL;
            s_q.el      <= '0;
            s_q.started <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o    = s_q.mode;
    assign cnt_o     = s_q.cnt;
    assign el_o      = s_q.el;
    assign started_o = s_q.started;

    // R4
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_periodic(s_q.mode) |-> (s_q.el < {{PADW{1'b0}}, s_q.cnt}));

    // R10
    sat_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_periodic(s_q.mode) && !clr) |=> (s_q.el >= $past(s_q.el)));

    // R9
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_enables(s_q.mode) && !gate_i && !load_i) |=> $stable(s_q.el));
endmodule

// File: rtl/ichan_decode.sv
module ichan_decode
    import ichan_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int EL_W  = CNT_W + 2
) (
    input  ichan_mode_e       mode_i,
    input  logic [CNT_W:0]    cnt_i,
    input  logic [EL_W-1:0]   el_i,
    input  logic              started_i,
    output logic              out_o,
    output logic [CNT_W-1:0]  rdbk_o
);
    localparam int PADW = EL_W - CNT_W - 1;

    logic [EL_W-1:0] ext_cnt, ext_half, diff;
    logic [CNT_W:0]  half;
    logic [EL_W:0]   dbl, cnt2, red, sq_rd;

    always_comb begin
        ext_cnt  = {{PADW{1'b0}}, cnt_i};
        half     = (cnt_i + 1'b1) >> 1;
        ext_half = {{PADW{1'b0}}, half};
        diff     = ext_cnt - el_i;
        dbl      = {el_i, 1'b0};
        cnt2     = {1'b0, ext_cnt};
        red      = (dbl >= cnt2) ? (dbl - cnt2) : dbl;
        sq_rd    = cnt2 - red;

        rdbk_o = (mode_i == M_SQUARE) ? sq_rd[CNT_W-1:0] : diff[CNT_W-1:0];

        unique case (mode_i)
            M_TERM:     out_o = (el_i >= ext_cnt);
            M_ONESHOT:  out_o = (el_i <  ext_cnt);
            M_RATE:     out_o = started_i && (el_i == '0);
            M_SQUARE:   out_o = (el_i <  ext_half);
            M_SWSTROBE,
            M_HWSTROBE: out_o = (el_i == ext_cnt);
            default:    out_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/interval_channel.sv
module interval_channel
    import ichan_pkg::*;
#(
    parameter int   CNT_W     = 16,
    parameter logic IDLE_GATE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en_i,
    input  logic             gate_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [2:0]       load_mode_i,
    output logic             out_o,
    output logic [CNT_W-1:0] rdbk_o
);
    localparam int EL_W = CNT_W + 2;

    logic            gate_rise;
    ichan_mode_e     mode;
    logic [CNT_W:0]  cnt;
    logic [EL_W-1:0] el;
    logic            started;

    ichan_gate_edge #(.IDLE_GATE(IDLE_GATE)) u_edge (
        .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .rise_o(gate_rise)
    );

    ichan_tracker #(.CNT_W(CNT_W), .EL_W(EL_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i), .gate_i(gate_i),
        .gate_rise_i(gate_rise), .load_i(load_i), .load_val_i(load_val_i),
        .load_mode_i(load_mode_i), .mode_o(mode), .cnt_o(cnt), .el_o(el),
        .started_o(started)
    );

    ichan_decode #(.CNT_W(CNT_W), .EL_W(EL_W)) u_dec (
        .mode_i(mode), .cnt_i(cnt), .el_i(el), .started_i(started),
        .out_o(out_o), .rdbk_o(rdbk_o)
    );

    // R1
    load_rdbk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (rdbk_o == $past(load_val_i)));
endmodule

// File: tb/interval_channel_tb.sv
module interval_channel_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0, gate = 1'b1, load = 1'b0;
    logic [15:0] val = '0;
    logic [2:0]  mode = '0;
    logic        out;
    logic [15:0] rdbk;

    logic       s_tick = 1'b0, s_load = 1'b0;
    logic [3:0] s_val = '0;
    logic [2:0] s_mode = '0;
    logic       s_out;
    logic [3:0] s_rdbk;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    interval_channel u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .gate_i(gate),
        .load_i(load), .load_val_i(val), .load_mode_i(mode),
        .out_o(out), .rdbk_o(rdbk)
    );

    interval_channel #(.CNT_W(4)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .tick_en_i(s_tick), .gate_i(1'b1),
        .load_i(s_load), .load_val_i(s_val), .load_mode_i(s_mode),
        .out_o(s_out), .rdbk_o(s_rdbk)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_both(input string req, input logic o, input logic [15:0] r);
        chk({req, " out"}, {15'd0, out}, {15'd0, o});
        chk({req, " rdbk"}, rdbk, r);
    endtask

    task automatic do_load(input logic [2:0] m, input logic [15:0] v);
        load = 1'b1; mode = m; val = v;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic gate_pulse();
        gate = 1'b0; @(negedge clk);
        gate = 1'b1; @(negedge clk);
    endtask

    task automatic t_reset();
        chk_both("R11", 1'b0, 16'h0000);
        chk("R11 small", {12'd0, s_rdbk}, 16'h0000);
    endtask

    task automatic t_mode0();
        do_load(3'd0, 16'd5); chk_both("R1 R2", 1'b0, 16'd5);
        ticks(4); chk_both("R2", 1'b0, 16'd1);
        ticks(1); chk_both("R2", 1'b1, 16'd0);
        ticks(1); chk_both("R7", 1'b1, 16'hFFFF);
        do_load(3'd0, 16'd5); ticks(3); chk_both("R7", 1'b0, 16'd2);
        do_load(3'd0, 16'd5); chk_both("R1 reload", 1'b0, 16'd5);
    endtask

    task automatic t_gate_level();
        do_load(3'd0, 16'd10); ticks(2); chk_both("R9", 1'b0, 16'd8);
        gate = 1'b0; ticks(3); chk_both("R9 hold", 1'b0, 16'd8);
        gate = 1'b1; @(negedge clk); chk_both("R9 no restart", 1'b0, 16'd8);
        ticks(1); chk_both("R9", 1'b0, 16'd7);
        do_load(3'd4, 16'd3); ticks(1); chk_both("R9", 1'b0, 16'd2);
        gate_pulse(); chk_both("R9 mode4 no restart", 1'b0, 16'd2);
        ticks(1); ticks(1); chk_both("R6", 1'b1, 16'd0);
        ticks(1); chk_both("R6 R7", 1'b0, 16'hFFFF);
    endtask

    task automatic t_mode1();
        do_load(3'd1, 16'd3); chk_both("R3", 1'b1, 16'd3);
        ticks(2); chk_both("R3", 1'b1, 16'd1);
        ticks(1); chk_both("R3", 1'b0, 16'd0);
        gate_pulse(); chk_both("R8 mode1", 1'b1, 16'd3);
    endtask

    task automatic t_mode2();
        do_load(3'd2, 16'd4); chk_both("R4", 1'b0, 16'd4);
        ticks(3); chk_both("R4", 1'b0, 16'd1);
        ticks(1); chk_both("R4 wrap", 1'b1, 16'd4);
        ticks(1); chk_both("R4", 1'b0, 16'd3);
        ticks(3); chk_both("R4 second", 1'b1, 16'd4);
        ticks(1); gate_pulse(); chk_both("R8 mode2", 1'b0, 16'd4);
    endtask

    task automatic t_mode3();
        do_load(3'd3, 16'd5); chk_both("R5", 1'b1, 16'd5);
        ticks(1); chk_both("R5", 1'b1, 16'd3);
        ticks(1); chk_both("R5", 1'b1, 16'd1);
        ticks(1); chk_both("R5", 1'b0, 16'd4);
        ticks(1); chk_both("R5", 1'b0, 16'd2);
        ticks(1); chk_both("R5 period", 1'b1, 16'd5);
    endtask

    task automatic t_mode5();
        do_load(3'd5, 16'd4); ticks(2); chk_both("R6", 1'b0, 16'd2);
        gate_pulse(); chk_both("R8 mode5", 1'b0, 16'd4);
        ticks(4); chk_both("R6 strobe", 1'b1, 16'd0);
    endtask

    task automatic t_load_edge();
        do_load(3'd0, 16'd0); chk_both("R1 zero", 1'b0, 16'h0000);
        ticks(1); chk_both("R1 zero", 1'b0, 16'hFFFF);
        do_load(3'd6, 16'd2); ticks(2); chk_both("R1 alias6", 1'b1, 16'd2);
        do_load(3'd7, 16'd4); ticks(1); chk_both("R1 alias7", 1'b1, 16'd2);
    endtask

    task automatic t_saturate();
        s_load = 1'b1; s_mode = 3'd0; s_val = 4'd1;
        @(negedge clk);
        s_load = 1'b0; s_tick = 1'b1;
        repeat (70) @(negedge clk);
        s_tick = 1'b0;
        chk("R10 sat rdbk", {12'd0, s_rdbk}, 16'd2);
        chk("R10 sat out", {15'd0, s_out}, 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_gate_level();
        t_mode1();
        t_mode2();
        t_mode3();
        t_mode5();
        t_load_edge();
        t_saturate();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule